// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-driven master for the two-wire clause-22 station management bus used to configure Ethernet PHYs. Software loads a PHY number and a register number into an address word, then launches either a write (by storing a 16-bit value into the write-data word) or a read (by taking bit 0 of the command word from 0 to 1). The controller turns the request into a 64-bit serial frame on a divided management clock and drives or releases the shared data line through an output enable.

While a frame runs, a busy flag in the indication word is high. A read also raises a not-valid flag that drops in the same system cycle that the 16 sampled bits land in the read-status word. Setting the top bit of the configuration word aborts any frame and clears both flags; the low three bits of that word set the clock divider, so the management clock period is 2×(divider+1) system clocks.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration word reads 7, the indication, read-status and command words read 0, MDC is low and MDIO output enable is low.
- R2: A register write to offset 0x00 with bit 31 set aborts any frame; in the next cycle busy (indication bit 0), not-valid (indication bit 2), MDC and output enable are all low, and bit 31 reads back as 0 while bits 2:0 hold the new divider.
- R3: During a frame MDC has a period of 2×(divider+1) system clocks, the divider being configuration bits 2:0.
- R4: The address word at offset 0x08 keeps the PHY number in bits 12:8 and the register number in bits 4:0; these read back and every other bit reads 0.
- R5: A register write to offset 0x0C while idle starts a write frame: 32 ones, start 01, opcode 01, PHY 5 bits, register 5 bits, turnaround 10, then the 16 data bits from write-data bits 15:0, each field MSB first, with output enable high for all 64 bits.
- R6: A register write to offset 0x04 that takes bit 0 from 0 to 1 while idle starts a read frame with opcode 10; output enable goes low from bit 46 (first turnaround bit, counting from 0 at the first preamble bit) to the end; rewriting 1 while the bit is already 1 starts nothing.
- R7: In a read frame, MDIO input is sampled on the rising MDC edge of bits 48 to 63, and the 16 bits, first sample in bit 15, appear in read-status bits 15:0 at offset 0x10.
- R8: Indication bit 0 (busy) is high from the cycle after a frame starts until the system clock edge of the falling MDC edge that ends bit 63, for reads and writes alike.
- R9: Indication bit 2 (not-valid) rises together with busy for a read, is never set by a write, and clears in the same cycle the read-status word is loaded.
- R10: A write start or a read start requested while busy is ignored: the running frame is not changed and no further frame follows.
- R11: MDIO output and output enable change only on the system clock edge where MDC falls (or where a frame starts or stops).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven onto the line |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Serial data read from the line |

## Verification
Busy and not-valid appear one system cycle after the clock edge that takes a register write, so the bench reads the indication word at the falling clock edge right after each write. Frame bits are captured by a PHY model on every rising MDC, read data is driven on falling MDC so it is stable at the sampling edge, and the MDC period is measured between successive rising edges. Status and flag clearing are checked after polling busy once per cycle, since both change on the same edge that ends bit 63.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 32;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int VAL_W      = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_POS     = PRE_BITS + 2 + 2 + PHY_W + REG_W;
    localparam int DATA_POS   = TA_POS + 2;

    typedef enum logic [2:0] {
        W_CFG  = 3'd0,
        W_CMD  = 3'd1,
        W_ADDR = 3'd2,
        W_CTRL = 3'd3,
        W_STAT = 3'd4,
        W_IND  = 3'd5
    } reg_word_e;

    typedef struct packed {
        logic             is_rd;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regn;
        logic [VAL_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        logic [1:0]       op;
        logic [1:0]       ta;
        logic [VAL_W-1:0] tail;
        op   = r.is_rd ? 2'b10 : 2'b01;
        ta   = r.is_rd ? 2'b11 : 2'b10;
        tail = r.is_rd ? {VAL_W{1'b1}} : r.wdata;
        return {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regn, ta, tail};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == div);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  mdio_req_t        req,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [VAL_W-1:0] rd_data,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

    logic                  rd_q;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      idx_nxt;
    logic [FRAME_BITS-1:0] shreg;

    assign idx_nxt = idx + 1'b1;
    assign done    = busy && fall_evt && (idx == LAST_IDX);
    assign mdio_o  = shreg[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy    <= 1'b0;
            rd_q    <= 1'b0;
            idx     <= '0;
            shreg   <= '1;
            mdio_oe <= 1'b0;
            if (rst) rd_data <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                rd_q    <= req.is_rd;
                idx     <= '0;
                shreg   <= build_frame(req);
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise_evt && rd_q && idx >= DATA_IDX)
                rd_data <= {rd_data[VAL_W-2:0], mdio_i};
            if (fall_evt) begin
                if (idx == LAST_IDX) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    shreg   <= '1;
                end else begin
                    idx     <= idx_nxt;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
                    mdio_oe <= !(rd_q && idx_nxt >= TA_IDX);
                end
            end
        end
    end

    // R11
    pin_stable_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(fall_evt) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy && rd_q && idx >= TA_IDX |-> !mdio_oe);

    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !rd_q |-> mdio_oe);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$past(abort) |-> idx >= $past(idx));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W    = 3,
    parameter int DIV_INIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int RST_BIT = DATA_W - 1;

    logic [2:0]       word;
    logic [DIV_W-1:0] div_q;
    logic             cmd_q;
    logic [PHY_W-1:0] phy_q;
    logic [REG_W-1:0] regn_q;
    logic [VAL_W-1:0] wval_q;
    logic [VAL_W-1:0] stat_q;
    logic             nv_q;

    logic             mgmt_rst;
    logic             wr_start;
    logic             rd_start;
    logic             busy;
    logic             done;
    logic             rise_evt;
    logic             fall_evt;
    logic [VAL_W-1:0] cap_data;
    mdio_req_t        req;

    assign word     = bus_addr[ADDR_W-1:2];
    assign mgmt_rst = bus_wr && word == W_CFG && bus_wdata[RST_BIT];
    assign wr_start = bus_wr && word == W_CTRL;
    assign rd_start = bus_wr && word == W_CMD && bus_wdata[0] && !cmd_q;

    assign req.is_rd = rd_start;
    assign req.phy   = phy_q;
    assign req.regn  = regn_q;
    assign req.wdata = bus_wdata[VAL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_INIT);
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
            wval_q <= '0;
            stat_q <= '0;
            nv_q   <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (word)
                    W_CFG:   div_q <= bus_wdata[DIV_W-1:0];
                    W_CMD:   cmd_q <= bus_wdata[0];
                    W_ADDR: begin
                        phy_q  <= bus_wdata[8 +: PHY_W];
                        regn_q <= bus_wdata[0 +: REG_W];
                    end
                    W_CTRL:  wval_q <= bus_wdata[VAL_W-1:0];
                    default: ;
                endcase
            end
            if (mgmt_rst)
                nv_q <= 1'b0;
            else if (rd_start && !busy)
                nv_q <= 1'b1;
            else if (done)
                nv_q <= 1'b0;
            if (done && nv_q)
                stat_q <= cap_data;
        end
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy & ~mgmt_rst),
        .div      (div_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .abort    (mgmt_rst),
        .start    (wr_start | rd_start),
        .req      (req),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .rd_data  (cap_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_CFG:   bus_rdata[DIV_W-1:0] = div_q;
            W_CMD:   bus_rdata[0] = cmd_q;
            W_ADDR: begin
                bus_rdata[8 +: PHY_W] = phy_q;
                bus_rdata[0 +: REG_W] = regn_q;
            end
            W_CTRL:  bus_rdata[VAL_W-1:0] = wval_q;
            W_STAT:  bus_rdata[VAL_W-1:0] = stat_q;
            W_IND: begin
                bus_rdata[0] = busy;
                bus_rdata[2] = nv_q;
            end
            default: ;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[RST_BIT-1:VAL_W]};

    // R9
    nv_busy_chk: assert property (@(posedge clk) disable iff (rst)
        nv_q |-> busy);

    // R2
    mgmt_rst_chk: assert property (@(posedge clk) disable iff (rst)
        mgmt_rst |=> !busy && !nv_q && !mdc && !mdio_oe);

    // R8
    wr_start_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start && !busy |=> busy);

    // R9
    wr_no_nv_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start && !busy && !nv_q |=> !nv_q);

endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/100ps
module tb_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mdio_mgmt_master dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model
    int          bitn = 0;
    logic [63:0] cap_o = '0, cap_oe = '0;
    time         t_last = 0, per = 0;
    logic        rd_mode = 1'b0;
    logic [15:0] phy_data = '0;

    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        bitn   = bitn + 1;
        if (t_last != 0) per = $time - t_last;
        t_last = $time;
    end

    always @(negedge mdc) begin
        if (rd_mode && bitn >= 48 && bitn <= 63) mdio_i = phy_data[63 - bitn];
        else mdio_i = 1'b1;
    end

    // pin-change monitor for R11
    int   viol = 0;
    logic pmdc = 1'b0, po = 1'b1, poe = 1'b0;
    always @(negedge clk) begin
        if (mdc && pmdc && (mdio_o !== po || mdio_oe !== poe)) viol++;
        pmdc = mdc; po = mdio_o; poe = mdio_oe;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic phy_arm(logic rd, logic [15:0] d);
        bitn = 0; cap_o = '0; cap_oe = '0; t_last = 0; per = 0;
        rd_mode = rd; phy_data = d;
    endtask

    task automatic wait_idle(string tag);
        logic [31:0] r;
        r = 32'h1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            bus_read(5'h14, r);
            if (!r[0]) break;
        end
        chk({tag, " busy clears"}, {63'd0, r[0]}, 64'd0);
    endtask

    // {is_rd, div[2:0], phy[4:0], reg[4:0], data[15:0]}
    localparam logic [29:0] VEC [6] = '{
        {1'b0, 3'd1, 5'h01, 5'h00, 16'h1234},
        {1'b1, 3'd1, 5'h1F, 5'h1F, 16'hA5C3},
        {1'b0, 3'd0, 5'h10, 5'h0A, 16'hFFFF},
        {1'b1, 3'd0, 5'h00, 5'h01, 16'h0001},
        {1'b0, 3'd7, 5'h15, 5'h12, 16'h8000},
        {1'b1, 3'd3, 5'h0A, 5'h05, 16'h7E81}
    };

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] exp_f, exp_oe;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(5'h00, r); chk("R1 cfg", r, 64'd7);
        bus_read(5'h14, r); chk("R1 ind", r, 64'd0);
        bus_read(5'h10, r); chk("R1 status", r, 64'd0);
        bus_read(5'h04, r); chk("R1 cmd", r, 64'd0);
        chk("R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);

        // R4 address word fields
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, r); chk("R4 addr readback", r, 64'h1F1F);

        foreach (VEC[i]) begin
            logic        rd;
            logic [2:0]  dv;
            logic [4:0]  ph, rg;
            logic [15:0] dt;
            {rd, dv, ph, rg, dt} = VEC[i];
            bus_write(5'h00, {29'd0, dv});
            bus_write(5'h08, {19'd0, ph, 3'd0, rg});
            phy_arm(rd, dt);
            if (rd) begin
                bus_write(5'h04, 32'd0);
                bus_write(5'h04, 32'd1);
            end else begin
                bus_write(5'h0C, {16'd0, dt});
            end
            bus_read(5'h14, r);
            chk(rd ? "R9 nv and busy set on read" : "R8 busy set on write",
                r, rd ? 64'd5 : 64'd1);
            wait_idle(rd ? "R8 read" : "R8 write");
            exp_f  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, ph, rg, 2'b10, dt};
            exp_oe = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
            if (rd) chk("R6 read header", {18'd0, cap_o[63:18]}, {18'd0, exp_f[63:18]});
            else    chk("R5 write frame", cap_o, exp_f);
            chk(rd ? "R6 read oe pattern" : "R5 write oe pattern", cap_oe, exp_oe);
            chk("R5 bit count", bitn, 64);
            chk("R3 mdc period", per, 10 * (dv + 1));
            bus_read(5'h14, r); chk("R9 flags clear", r, 64'd0);
            if (rd) begin
                bus_read(5'h10, r); chk("R7 status data", r, {48'd0, dt});
            end
        end

        // R6 level held high does not retrigger
        phy_arm(1'b1, 16'h0);
        bus_write(5'h04, 32'd1);
        bus_read(5'h14, r); chk("R6 no retrigger ind", r, 64'd0);
        repeat (40) @(negedge clk);
        chk("R6 no retrigger mdc", bitn, 0);

        // R10 starts while busy are ignored
        bus_write(5'h00, 32'd1);
        bus_write(5'h08, {19'd0, 5'h03, 3'd0, 5'h04});
        phy_arm(1'b0, 16'h0);
        bus_write(5'h0C, 32'h0000_C3C3);
        repeat (10) @(negedge clk);
        bus_write(5'h0C, 32'h0000_1111);
        bus_write(5'h04, 32'd0);
        bus_write(5'h04, 32'd1);
        bus_read(5'h14, r); chk("R10 read start ignored while busy", r, 64'd1);
        wait_idle("R10");
        repeat (200) @(negedge clk);
        chk("R10 single frame", bitn, 64);
        chk("R10 frame data kept", cap_o,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'hC3C3});
        bus_read(5'h14, r); chk("R10 ind idle", r, 64'd0);

        // R2 abort a running read
        bus_write(5'h04, 32'd0);
        phy_arm(1'b1, 16'hBEEF);
        bus_write(5'h04, 32'd1);
        repeat (30) @(negedge clk);
        bus_write(5'h00, 32'h8000_0002);
        bus_read(5'h14, r); chk("R2 flags cleared", r, 64'd0);
        chk("R2 pins low", {62'd0, mdc, mdio_oe}, 64'd0);
        bus_read(5'h00, r); chk("R2 cfg readback", r, 64'd2);
        repeat (50) @(negedge clk);
        chk("R2 mdc stays low", {63'd0, mdc}, 64'd0);

        // R2 a frame after abort is whole
        phy_arm(1'b0, 16'h5A5A);
        bus_write(5'h0C, 32'h0000_5A5A);
        wait_idle("R2 after abort");
        chk("R2 frame after abort", cap_o,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h5A5A});
        chk("R3 period after abort", per, 30);

        chk("R11 pins change only at mdc fall", viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule